// File: doc/BRIEF.md
# Clear-on-read event counters with half-scale interrupt

This block is a small statistics unit that keeps two independent event tallies. The first counts receive frames that were lost because the receive buffer was emptied too slowly. The second counts transmit collisions. The MAC sends a one-cycle pulse for each event. The host reads either tally through a simple read port made of a strobe, an address and a data word.

Each tally sits in the upper ten bits of a 16-bit word. The lower six bits hold a fixed identifier for that register. A read returns the current value and clears the tally in the same cycle. Each tally has its own interrupt enable. When the enable is set, a sticky interrupt flag rises as the tally passes half scale, which leaves 512 more counts before the tally wraps. The flag stays set until the host acknowledges it.

Top module: `event_tally`

## Requirements
- R1: After reset both tallies are zero and both interrupt outputs are low.
- R2: Each `missPulse` cycle adds one to the missed-receive tally. A read at address 0x0 returns that tally in `rdData[15:6]`, with bit 6 as the least significant bit.
- R3: Each `colPulse` cycle adds one to the collision tally, which is read at address 0x2. The two tallies are counted independently, including when both pulses arrive in the same cycle.
- R4: `rdData[5:0]` reads 0x10 for the missed-receive word and 0x12 for the collision word. A read of any other address returns 0x0000. `rdData` is combinational and valid during the `rdStrobe` cycle.
- R5: A read clears the addressed tally to zero at the next clock edge. The other tally is not affected.
- R6: If an event and a read of the same tally fall in one cycle, the read returns the value before the increment, and the tally holds 1 afterwards.
- R7: A tally at 0x3FF wraps to 0x000 on its next event.
- R8: When its enable is set, an interrupt flag rises in the cycle after an event moves its tally from 0x1FF to 0x200, and at no other transition. `missIrqEn` corresponds to configuration bit 13 and `colIrqEn` to bit 12.
- R9: With its enable clear, a crossing of 0x1FF to 0x200 leaves the flag low.
- R10: A raised flag stays high until its acknowledge input is pulsed, and then goes low at the next edge. If a new crossing and an acknowledge fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missPulse | input | 1 | One-cycle pulse for a lost receive frame |
| colPulse | input | 1 | One-cycle pulse for a transmit collision |
| rdStrobe | input | 1 | Host read strobe |
| rdAddr | input | 4 | Host read address |
| rdData | output | 16 | Read data: tally in [15:6], identifier in [5:0] |
| missIrqEn | input | 1 | Interrupt enable for the missed-receive tally (configuration bit 13) |
| colIrqEn | input | 1 | Interrupt enable for the collision tally (configuration bit 12) |
| missAck | input | 1 | Clears the missed-receive interrupt flag |
| colAck | input | 1 | Clears the collision interrupt flag |
| missIrq | output | 1 | Sticky missed-receive interrupt |
| colIrq | output | 1 | Sticky collision interrupt |

## Verification
The bench builds the block with its default parameters: 10-bit tallies, a 16-bit word and a 4-bit address. A few thousand pulses are cheap at that width, so the bench can drive the half-scale crossing and the full wrap at their real values, not at a scaled-down copy. A behavioural reference model runs beside the block and checks both interrupt outputs on every clock. It also checks each read word, including a read that lands in the same cycle as an event and an acknowledge that meets a fresh crossing.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef struct packed {
    logic inc;
    logic clr;
  } cntStrobe_t;
endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int MISS_ADDR = 0,
  parameter int COL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missPulse,
  input  logic              colPulse,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        irqEn,
  input  logic [1:0]        irqAck,
  input  logic [1:0]        preHalf,
  output cntStrobe_t        strb [2],
  output logic [1:0]        irqFlag
);
  logic [1:0] pulse;
  logic [1:0] rdHit;

  assign pulse = {colPulse, missPulse};
  assign rdHit[0] = rdStrobe && (rdAddr == ADDR_W'(MISS_ADDR));
  assign rdHit[1] = rdStrobe && (rdAddr == ADDR_W'(COL_ADDR));

  for (genvar g = 0; g < 2; g++) begin : gCh
    logic crossing;

    assign strb[g].inc = pulse[g];
    assign strb[g].clr = rdHit[g];
    assign crossing = pulse[g] && !rdHit[g] && preHalf[g] && irqEn[g];

    always_ff @(posedge clk) begin
      if (!rstN)         irqFlag[g] <= 1'b0;
      else if (crossing) irqFlag[g] <= 1'b1;
      else if (irqAck[g]) irqFlag[g] <= 1'b0;
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlag[g] && !irqAck[g]) |=> irqFlag[g]);
    // R9
    irq_no_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!irqFlag[g] && !(irqEn[g] && pulse[g] && preHalf[g])) |=> !irqFlag[g]);
    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqAck[g] && !pulse[g]) |=> !irqFlag[g]);
  end
endmodule

// File: rtl/tally_data.sv
module tally_data
  import tally_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int MISS_ADDR = 0,
  parameter int COL_ADDR = 2,
  parameter int MISS_ID = 'h10,
  parameter int COL_ID = 'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strb [2],
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [1:0]        preHalf
);
  localparam int ID_W = WORD_W - CNT_W;
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ [2];

  for (genvar g = 0; g < 2; g++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)           cntQ[g] <= '0;
      else if (strb[g].clr) cntQ[g] <= strb[g].inc ? CNT_W'(1) : '0;
      else if (strb[g].inc) cntQ[g] <= cntQ[g] + CNT_W'(1);
    end

    assign preHalf[g] = (cntQ[g] == HALF_M1);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[g].inc && !strb[g].clr && cntQ[g] != CNT_MAX) |=> (cntQ[g] > $past(cntQ[g])));
    // R7
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[g].inc && !strb[g].clr && cntQ[g] == CNT_MAX) |=> (cntQ[g] == '0));
    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[g].clr && !strb[g].inc) |=> (cntQ[g] == '0));
    // R6
    cnt_clr_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[g].clr && strb[g].inc) |=> (cntQ[g] == CNT_W'(1)));
    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[g].clr && !strb[g].inc) |=> $stable(cntQ[g]));
  end

  always_comb begin
    rdData = '0;
    if (rdStrobe) begin
      if (rdAddr == ADDR_W'(MISS_ADDR))     rdData = {cntQ[0], ID_W'(MISS_ID)};
      else if (rdAddr == ADDR_W'(COL_ADDR)) rdData = {cntQ[1], ID_W'(COL_ID)};
    end
  end
endmodule

// File: rtl/event_tally.sv
module event_tally
  import tally_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int MISS_ADDR = 0,
  parameter int COL_ADDR = 2,
  parameter int MISS_ID = 'h10,
  parameter int COL_ID = 'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missPulse,
  input  logic              colPulse,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic              missIrqEn,
  input  logic              colIrqEn,
  input  logic              missAck,
  input  logic              colAck,
  output logic              missIrq,
  output logic              colIrq
);
  cntStrobe_t strb [2];
  logic [1:0] preHalf;
  logic [1:0] irqFlag;

  tally_ctrl #(
    .ADDR_W(ADDR_W), .MISS_ADDR(MISS_ADDR), .COL_ADDR(COL_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .missPulse(missPulse), .colPulse(colPulse),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .irqEn({colIrqEn, missIrqEn}),
    .irqAck({colAck, missAck}), .preHalf(preHalf), .strb(strb), .irqFlag(irqFlag)
  );

  tally_data #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .MISS_ADDR(MISS_ADDR),
    .COL_ADDR(COL_ADDR), .MISS_ID(MISS_ID), .COL_ID(COL_ID)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdData(rdData), .preHalf(preHalf)
  );

  assign missIrq = irqFlag[0];
  assign colIrq  = irqFlag[1];
endmodule

// File: tb/sim_event_tally.sv
module sim_event_tally;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missPulse = 1'b0, colPulse = 1'b0, rdStrobe = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [15:0] rdData;
  logic missIrqEn = 1'b0, colIrqEn = 1'b0, missAck = 1'b0, colAck = 1'b0;
  logic missIrq, colIrq;

  int total = 0;
  int bad = 0;
  int mCnt = 0, cCnt = 0;
  bit mIrq = 0, cIrq = 0;

  always #(PERIOD/2) clk = ~clk;

  event_tally u0 (
    .clk(clk), .rstN(rstN), .missPulse(missPulse), .colPulse(colPulse),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData),
    .missIrqEn(missIrqEn), .colIrqEn(colIrqEn), .missAck(missAck),
    .colAck(colAck), .missIrq(missIrq), .colIrq(colIrq)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expWord(logic [3:0] a);
    if (a == 4'h0) return (mCnt << 6) | 'h10;
    if (a == 4'h2) return (cCnt << 6) | 'h12;
    return 0;
  endfunction

  task automatic step(bit m, bit c, bit rd, logic [3:0] a, bit ma, bit ca, string tag);
    bit mClr, cClr;
    @(negedge clk);
    missPulse = m; colPulse = c; rdStrobe = rd; rdAddr = a; missAck = ma; colAck = ca;
    #1;
    if (rd) check(tag, int'(rdData), expWord(a));
    check("R8 R10 missIrq", int'(missIrq), int'(mIrq));
    check("R8 R10 colIrq", int'(colIrq), int'(cIrq));
    @(posedge clk);
    mClr = rd && a == 4'h0;
    cClr = rd && a == 4'h2;
    if (m && !mClr && mCnt == 511 && missIrqEn) mIrq = 1;
    else if (ma) mIrq = 0;
    if (c && !cClr && cCnt == 511 && colIrqEn) cIrq = 1;
    else if (ca) cIrq = 0;
    if (mClr) mCnt = m ? 1 : 0;
    else if (m) mCnt = (mCnt + 1) % 1024;
    if (cClr) cCnt = c ? 1 : 0;
    else if (c) cCnt = (cCnt + 1) % 1024;
  endtask

  task automatic idle(); step(0, 0, 0, 4'h0, 0, 0, "idle"); endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    step(0, 0, 1, 4'h0, 0, 0, "R1 miss word");
    step(0, 0, 1, 4'h2, 0, 0, "R1 col word");
    // R2 increments
    for (int i = 0; i < 5; i++) step(1, 0, 0, 4'h0, 0, 0, "R2");
    step(0, 0, 1, 4'h0, 0, 0, "R2 miss after 5");
    // R5 cleared after read
    step(0, 0, 1, 4'h0, 0, 0, "R5 miss cleared");
    // R3 simultaneous events
    for (int i = 0; i < 7; i++) step(1, 1, 0, 4'h0, 0, 0, "R3");
    step(0, 0, 1, 4'h2, 0, 0, "R3 col after 7");
    step(0, 0, 1, 4'h0, 0, 0, "R3 miss after 7");
    // R4 unknown address and ids
    step(0, 0, 1, 4'h5, 0, 0, "R4 unmapped");
    step(0, 1, 1, 4'h0, 0, 0, "R4 miss id");
    step(0, 0, 1, 4'h2, 0, 0, "R4 col id");
    // R6 read with event in the same cycle
    for (int i = 0; i < 3; i++) step(1, 0, 0, 4'h0, 0, 0, "R6");
    step(1, 0, 1, 4'h0, 0, 0, "R6 pre-increment value");
    step(0, 0, 1, 4'h0, 0, 0, "R6 left at one");
    // R8 crossing with enable
    missIrqEn = 1'b1;
    for (int i = 0; i < 511; i++) step(1, 0, 0, 4'h0, 0, 0, "R8");
    check("R8 no irq at 0x1FF", int'(missIrq), 0);
    step(1, 0, 0, 4'h0, 0, 0, "R8");
    idle();
    check("R8 irq after 0x200", int'(missIrq), 1);
    // R10 sticky
    for (int i = 0; i < 20; i++) idle();
    check("R10 held", int'(missIrq), 1);
    // R7 wrap
    for (int i = 0; i < 511; i++) step(1, 0, 0, 4'h0, 0, 0, "R7");
    step(0, 0, 1, 4'h0, 0, 0, "R7 at max");
    for (int i = 0; i < 1023; i++) step(1, 0, 0, 4'h0, 0, 0, "R7");
    step(1, 0, 0, 4'h0, 0, 0, "R7");
    step(0, 0, 1, 4'h0, 0, 0, "R7 wrapped");
    step(0, 0, 0, 4'h0, 1, 0, "R10 ack");
    idle();
    check("R10 acked", int'(missIrq), 0);
    // R9 disabled collision
    step(0, 0, 1, 4'h2, 0, 0, "R9 clear col");
    for (int i = 0; i < 600; i++) step(0, 1, 0, 4'h0, 0, 0, "R9");
    idle();
    check("R9 no col irq", int'(colIrq), 0);
    // R10 set wins over ack
    colIrqEn = 1'b1;
    step(0, 0, 1, 4'h2, 0, 0, "R10 clear col");
    for (int i = 0; i < 511; i++) step(0, 1, 0, 4'h0, 0, 0, "R10");
    step(0, 1, 0, 4'h0, 0, 1, "R10 set with ack");
    idle();
    check("R10 set wins", int'(colIrq), 1);
    step(0, 0, 1, 4'h2, 0, 0, "R10 col at 0x200");
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule